// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block takes a DDR2 memory from power-up to its ready state. Out of reset it holds clock-enable low, waits out a clock-settling period, then raises clock-enable and walks the device through its fixed start-up order. That order is: precharge-all, the two upper extended mode register writes, DLL enable, mode register write with DLL reset, a second precharge-all, a configurable number of auto-refreshes, and the operating mode write. It ends with the off-chip-driver default/exit pair on extended register 1. After that it raises a ready flag and idles on NOP.

Every wait is a parameter counted in clock cycles. A bench can therefore shrink the 200 µs settle time and the 400 ns pre-charge pause to a few cycles. The operating mode word and the extended register 1 word come in as inputs. The sequencer forces the bits it owns: DLL reset, off-chip-driver field, DLL enable and bit 13. All pin outputs come from flops.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset (synchronous, active low) is asserted, ddr_cke=0, ddr_cs_n=1, ddr_odt=0 and init_done=0.
- R2: Counting edges from the first rising edge with reset released as edge 1, ddr_cke goes high at edge T_STABLE and never falls again before the next reset. While ddr_cke is low, ddr_cs_n stays 1.
- R3: The first command, precharge-all ({ras_n,cas_n,we_n}=010 with addr[10]=1), appears T_CKE_NOP edges after ddr_cke rises. Only NOP ({ras_n,cas_n,we_n}=111, cs_n=0) is driven in between.
- R4: The next four commands are mode writes ({ras_n,cas_n,we_n}=000), in this order. First ba=010 with addr=0. Then ba=011 with addr=0. Then ba=001 with emr1_val, where addr bits 0, 7, 8, 9 and 13 are cleared. Then ba=000 with mode_val, where addr[8]=1 and addr[13]=0.
- R5: After those come a precharge-all, then exactly N_REFRESH (at least 2) auto-refreshes ({ras_n,cas_n,we_n}=001), then a mode write with ba=000 carrying mode_val with addr[8]=0 and addr[13]=0.
- R6: Two writes with ba=001 follow. Both carry emr1_val with bits 0 and 13 cleared. The first has addr[9:7]=111 and the second has addr[9:7]=000. The first is issued no sooner than T_OCD_GAP edges after the DLL-reset write.
- R7: Each command is issued exactly its recovery wait after the previous one: T_MRD after a mode write, T_RP after a precharge-all, T_RFC after a refresh. The only exception is where R6's gap holds the off-chip-driver default write back.
- R8: Every command lasts one cycle. No read, write or activate encoding is ever driven, and ddr_odt stays 0.
- R9: init_done rises T_MRD edges after the off-chip-driver exit write. It stays high until reset, and only NOP is driven while it is high.
- R10: Asserting reset in any state, including mid-sequence and after completion, restores the R1 outputs on the next edge. A later release restarts the full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-side clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_val | input | 14 | Operating mode register word |
| emr1_val | input | 14 | Operating extended register 1 word |
| ddr_cke | output | 1 | Clock enable |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_odt | output | 1 | On-die termination, held low |
| ddr_ba | output | 3 | Bank address / register select |
| ddr_addr | output | 14 | Address / register data |
| init_done | output | 1 | Initialization complete |

## Verification
The bench uses a configuration where the off-chip-driver gap, not the recovery time, decides when the default write is issued. A design that ignored the gap would issue that write two cycles early, and one that added the gap on top of the recovery time would issue it late. The bench also probes the counter boundaries. An off-by-one in a wait counter moves every later command by one edge, and a reused wrong wait (T_MRD where T_RP belongs) skews only the command after a precharge-all. It runs operating words of all zeros, all ones and mixed patterns, so that a forced bit that leaks (DLL reset kept in the final mode write, or off-chip-driver bits left set in the DLL-enable write) shows up as a wrong address. Reset is asserted mid-refresh and after completion, to catch a sequencer whose state or ready flag survives reset.

// File: rtl/ddr2i_pkg.sv
// Shared types for the DDR2 start-up sequencer.
// Assumes the pin bundle is registered once at the top level.
package ddr2i_pkg;

    typedef struct packed {
        logic        cke;
        logic        cs_n;
        logic        ras_n;
        logic        cas_n;
        logic        we_n;
        logic [2:0]  ba;
        logic [13:0] addr;
    } ddr2i_bus_t;

    typedef enum logic [2:0] {
        K_NOP,
        K_PREA,
        K_REF,
        K_MRS,
        K_DESEL
    } ddr2i_kind_e;

    typedef enum logic [1:0] {
        PH_STABLE,
        PH_RUN,
        PH_DONE
    } ddr2i_phase_e;

    // Builds the pin bundle for one command kind.
    function automatic ddr2i_bus_t ddr2i_drive(input ddr2i_kind_e k,
                                               input logic [2:0] ba,
                                               input logic [13:0] a);
        ddr2i_bus_t b;
        b.cke   = 1'b1;
        b.cs_n  = 1'b0;
        b.ras_n = 1'b1;
        b.cas_n = 1'b1;
        b.we_n  = 1'b1;
        b.ba    = 3'b000;
        b.addr  = 14'h0000;
        case (k)
            K_PREA: begin
                b.ras_n = 1'b0;
                b.we_n  = 1'b0;
                b.addr  = a;
            end
            K_REF: begin
                b.ras_n = 1'b0;
                b.cas_n = 1'b0;
            end
            K_MRS: begin
                b.ras_n = 1'b0;
                b.cas_n = 1'b0;
                b.we_n  = 1'b0;
                b.ba    = ba;
                b.addr  = a;
            end
            K_DESEL: begin
                b.cke  = 1'b0;
                b.cs_n = 1'b1;
            end
            default: ;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/ddr2i_countdown.sv
// Loadable down-counter that saturates at zero.
// Assumes load_val fits W bits; is_zero reflects the registered count.
module ddr2i_countdown #(
    parameter int W       = 16,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         is_zero
);
    logic [W-1:0] cnt_q;

    // Count down to zero, reload on request, preset on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= W'(RST_VAL);
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign is_zero = (cnt_q == '0);

    // R7: a count in progress never jumps upward without a load.
    a_r7_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/ddr2i_step_decode.sv
// Maps a step index of the start-up order to its command, register
// select, address word and recovery wait (minus one).
// Assumes N_REFRESH >= 2 and every recovery wait >= 2.
module ddr2i_step_decode
    import ddr2i_pkg::*;
#(
    parameter int N_REFRESH = 2,
    parameter int T_MRD     = 2,
    parameter int T_RP      = 2,
    parameter int T_RFC     = 16,
    parameter int SW        = 4,
    parameter int CW        = 16
) (
    input  logic [SW-1:0] step,
    input  logic [13:0]   mode_val,
    input  logic [13:0]   emr1_val,
    output ddr2i_kind_e   kind,
    output logic [2:0]    ba,
    output logic [13:0]   addr,
    output logic [CW-1:0] wait_m1,
    output logic          gated,
    output logic          dll_rst,
    output logic          final_step
);
    localparam int S_REF0     = 6;
    localparam int S_MRS_OP   = S_REF0 + N_REFRESH;
    localparam int S_OCD_DEF  = S_MRS_OP + 1;
    localparam int S_OCD_EXIT = S_MRS_OP + 2;
    localparam int S_FINAL    = S_MRS_OP + 3;

    localparam logic [13:0] M_A0  = 14'h0001;
    localparam logic [13:0] M_A8  = 14'h0100;
    localparam logic [13:0] M_OCD = 14'h0380;
    localparam logic [13:0] M_A10 = 14'h0400;
    localparam logic [13:0] M_A13 = 14'h2000;

    logic [13:0] emr1_base;
    logic [13:0] mode_base;
    int          s;

    assign emr1_base = emr1_val & ~(M_A0 | M_A13 | M_OCD);
    assign mode_base = mode_val & ~(M_A8 | M_A13);
    assign s         = int'(step);

    // Select the command and its recovery wait for the current step.
    always_comb begin
        kind       = K_NOP;
        ba         = 3'b000;
        addr       = 14'h0000;
        wait_m1    = CW'(T_MRD - 1);
        gated      = 1'b0;
        dll_rst    = 1'b0;
        final_step = 1'b0;
        if (s == 0 || s == 5) begin
            kind    = K_PREA;
            addr    = M_A10;
            wait_m1 = CW'(T_RP - 1);
        end else if (s == 1) begin
            kind = K_MRS;
            ba   = 3'b010;
        end else if (s == 2) begin
            kind = K_MRS;
            ba   = 3'b011;
        end else if (s == 3) begin
            kind = K_MRS;
            ba   = 3'b001;
            addr = emr1_base;
        end else if (s == 4) begin
            kind    = K_MRS;
            addr    = mode_base | M_A8;
            dll_rst = 1'b1;
        end else if (s >= S_REF0 && s < S_MRS_OP) begin
            kind    = K_REF;
            wait_m1 = CW'(T_RFC - 1);
        end else if (s == S_MRS_OP) begin
            kind = K_MRS;
            addr = mode_base;
        end else if (s == S_OCD_DEF) begin
            kind  = K_MRS;
            ba    = 3'b001;
            addr  = emr1_base | M_OCD;
            gated = 1'b1;
        end else if (s == S_OCD_EXIT) begin
            kind = K_MRS;
            ba   = 3'b001;
            addr = emr1_base;
        end else if (s == S_FINAL) begin
            final_step = 1'b1;
        end
    end

    // R5: the parameter set must allow two refreshes and one-cycle commands.
    initial begin
        a_r5_param_floor: assert (N_REFRESH >= 2 && T_MRD >= 2 && T_RP >= 2 && T_RFC >= 2)
            else $error("sequencer parameters below their floor");
    end
endmodule

// File: rtl/ddr2_init_seq.sv
// DDR2 power-up initialization sequencer.
// Holds CKE low for T_STABLE cycles, then runs the fixed start-up order
// with parameterized recovery waits, and raises init_done at the end.
// Assumes the clock is running while reset is released; outputs registered.
module ddr2_init_seq
    import ddr2i_pkg::*;
#(
    parameter int T_STABLE  = 25000,
    parameter int T_CKE_NOP = 50,
    parameter int T_MRD     = 2,
    parameter int T_RP      = 2,
    parameter int T_RFC     = 16,
    parameter int N_REFRESH = 2,
    parameter int T_OCD_GAP = 200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [13:0] mode_val,
    input  logic [13:0] emr1_val,
    output logic        ddr_cke,
    output logic        ddr_cs_n,
    output logic        ddr_ras_n,
    output logic        ddr_cas_n,
    output logic        ddr_we_n,
    output logic        ddr_odt,
    output logic [2:0]  ddr_ba,
    output logic [13:0] ddr_addr,
    output logic        init_done
);
    localparam int CW = $clog2(T_STABLE + T_CKE_NOP + T_MRD + T_RP + T_RFC + T_OCD_GAP) + 1;
    localparam int SW = $clog2(N_REFRESH + 10);

    ddr2i_phase_e  phase_q, phase_d;
    logic [SW-1:0] step_q, step_d;
    logic          done_q, done_d;
    ddr2i_bus_t    bus_q, bus_d;

    logic          gap_load, gap_zero, ocd_load, ocd_zero;
    logic [CW-1:0] gap_val;

    ddr2i_kind_e   kind;
    logic [2:0]    st_ba;
    logic [13:0]   st_addr;
    logic [CW-1:0] wait_m1;
    logic          gated, dll_rst, final_step;

    ddr2i_countdown #(.W(CW), .RST_VAL(T_STABLE - 1)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .is_zero  (gap_zero)
    );

    ddr2i_countdown #(.W(CW), .RST_VAL(0)) u_ocd (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ocd_load),
        .load_val (CW'(T_OCD_GAP - 1)),
        .is_zero  (ocd_zero)
    );

    ddr2i_step_decode #(
        .N_REFRESH (N_REFRESH),
        .T_MRD     (T_MRD),
        .T_RP      (T_RP),
        .T_RFC     (T_RFC),
        .SW        (SW),
        .CW        (CW)
    ) u_dec (
        .step       (step_q),
        .mode_val   (mode_val),
        .emr1_val   (emr1_val),
        .kind       (kind),
        .ba         (st_ba),
        .addr       (st_addr),
        .wait_m1    (wait_m1),
        .gated      (gated),
        .dll_rst    (dll_rst),
        .final_step (final_step)
    );

    // Decide the next phase, step and pin bundle from the wait counters.
    always_comb begin
        phase_d  = phase_q;
        step_d   = step_q;
        done_d   = done_q;
        gap_load = 1'b0;
        gap_val  = '0;
        ocd_load = 1'b0;
        bus_d    = ddr2i_drive(K_NOP, 3'b000, 14'h0000);
        unique case (phase_q)
            PH_STABLE: begin
                bus_d = ddr2i_drive(K_DESEL, 3'b000, 14'h0000);
                if (gap_zero) begin
                    phase_d  = PH_RUN;
                    gap_load = 1'b1;
                    gap_val  = CW'(T_CKE_NOP - 1);
                    bus_d    = ddr2i_drive(K_NOP, 3'b000, 14'h0000);
                end
            end
            PH_RUN: begin
                if (gap_zero && (!gated || ocd_zero)) begin
                    if (final_step) begin
                        phase_d = PH_DONE;
                        done_d  = 1'b1;
                    end else begin
                        bus_d    = ddr2i_drive(kind, st_ba, st_addr);
                        gap_load = 1'b1;
                        gap_val  = wait_m1;
                        step_d   = step_q + 1'b1;
                        ocd_load = dll_rst;
                    end
                end
            end
            PH_DONE: ;
            default: phase_d = PH_STABLE;
        endcase
    end

    // Register state and every pin so the outputs are glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_STABLE;
            step_q  <= '0;
            done_q  <= 1'b0;
            bus_q   <= ddr2i_drive(K_DESEL, 3'b000, 14'h0000);
        end else begin
            phase_q <= phase_d;
            step_q  <= step_d;
            done_q  <= done_d;
            bus_q   <= bus_d;
        end
    end

    assign ddr_cke   = bus_q.cke;
    assign ddr_cs_n  = bus_q.cs_n;
    assign ddr_ras_n = bus_q.ras_n;
    assign ddr_cas_n = bus_q.cas_n;
    assign ddr_we_n  = bus_q.we_n;
    assign ddr_ba    = bus_q.ba;
    assign ddr_addr  = bus_q.addr;
    assign ddr_odt   = 1'b0;
    assign init_done = done_q;

    logic cmd_on;
    logic ocd_def_on;
    assign cmd_on     = !ddr_cs_n && !(ddr_ras_n && ddr_cas_n && ddr_we_n);
    assign ocd_def_on = cmd_on && !ddr_ras_n && !ddr_cas_n && !ddr_we_n
                        && ddr_ba == 3'b001 && ddr_addr[9:7] == 3'b111;

    // R10: reset restores the idle pins on the following edge.
    a_r10_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!ddr_cke && ddr_cs_n && !init_done));

    // R2: clock-enable never falls once raised; nothing selected while low.
    a_r2_cke_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ddr_cke |=> ddr_cke);
    a_r2_desel_low_cke: assert property (@(posedge clk) disable iff (!rst_n)
        !ddr_cke |-> ddr_cs_n);

    // R8: one-cycle commands, never a column or activate command.
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_on |=> !cmd_on);
    a_r8_no_column: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ddr_cs_n && ddr_ras_n && !ddr_cas_n));
    a_r8_no_activate: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ddr_cs_n && !ddr_ras_n && ddr_cas_n && ddr_we_n));

    // R6: the driver-default write only after the post-DLL-reset gap.
    a_r6_ocd_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ocd_def_on |-> $past(ocd_zero));

    // R9: ready flag is sticky and the bus idles behind it.
    a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
    a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> !cmd_on);
endmodule

// File: tb/tb_ddr2_init_seq.sv
module tb_ddr2_init_seq;
    localparam int TS   = 20;
    localparam int TCN  = 5;
    localparam int MRD  = 2;
    localparam int RP   = 3;
    localparam int RFC  = 7;
    localparam int NR   = 3;
    localparam int GAP  = 30;
    localparam int RUN_EDGES = 90;
    localparam int NCMD = 9 + NR;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] mode_val = 14'h0;
    logic [13:0] emr1_val = 14'h0;
    logic        ddr_cke, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n, ddr_odt, init_done;
    logic [2:0]  ddr_ba;
    logic [13:0] ddr_addr;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    ddr2_init_seq #(
        .T_STABLE (TS), .T_CKE_NOP (TCN), .T_MRD (MRD), .T_RP (RP),
        .T_RFC (RFC), .N_REFRESH (NR), .T_OCD_GAP (GAP)
    ) dut (
        .clk (clk), .rst_n (rst_n), .mode_val (mode_val), .emr1_val (emr1_val),
        .ddr_cke (ddr_cke), .ddr_cs_n (ddr_cs_n), .ddr_ras_n (ddr_ras_n),
        .ddr_cas_n (ddr_cas_n), .ddr_we_n (ddr_we_n), .ddr_odt (ddr_odt),
        .ddr_ba (ddr_ba), .ddr_addr (ddr_addr), .init_done (init_done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic hold_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "cke in reset", int'(ddr_cke), 0);
        chk("R1", "cs_n in reset", int'(ddr_cs_n), 1);
        chk("R1", "odt in reset", int'(ddr_odt), 0);
        chk("R1", "done in reset", int'(init_done), 0);
    endtask

    // One full sequence from reset, checked against an arithmetic schedule.
    task automatic run_seq(input logic [13:0] mv, input logic [13:0] ev);
        int et[NCMD];
        int ec[NCMD];
        int eb[NCMD];
        int ea[NCMD];
        string er[NCMD];
        int rt[NCMD];
        int rc[NCMD];
        int rb[NCMD];
        int ra[NCMD];
        int n = 0;
        int cke_rise = -1;
        int done_rise = -1;
        int bad_cke = 0, bad_done = 0, bad_len = 0, bad_col = 0, bad_odt = 0, bad_quiet = 0;
        logic prev_act = 1'b0;
        int emr_b, mode_b, t, k_ocd, exp_done;

        mode_val = mv;
        emr1_val = ev;
        emr_b  = int'(ev & ~14'h2381);
        mode_b = int'(mv & ~14'h2100);

        // Expected schedule.
        t = TS + TCN;
        et[0] = t; ec[0] = 2; eb[0] = 0; ea[0] = 14'h0400; er[0] = "R3"; t += RP;
        et[1] = t; ec[1] = 0; eb[1] = 2; ea[1] = 0;        er[1] = "R4"; t += MRD;
        et[2] = t; ec[2] = 0; eb[2] = 3; ea[2] = 0;        er[2] = "R4"; t += MRD;
        et[3] = t; ec[3] = 0; eb[3] = 1; ea[3] = emr_b;    er[3] = "R4"; t += MRD;
        et[4] = t; ec[4] = 0; eb[4] = 0; ea[4] = mode_b | 14'h0100; er[4] = "R4"; t += MRD;
        et[5] = t; ec[5] = 2; eb[5] = 0; ea[5] = 14'h0400; er[5] = "R5"; t += RP;
        for (int r = 0; r < NR; r++) begin
            et[6+r] = t; ec[6+r] = 1; eb[6+r] = 0; ea[6+r] = 0; er[6+r] = "R5"; t += RFC;
        end
        et[6+NR] = t; ec[6+NR] = 0; eb[6+NR] = 0; ea[6+NR] = mode_b; er[6+NR] = "R5"; t += MRD;
        k_ocd = 7 + NR;
        if (et[4] + GAP > t) t = et[4] + GAP;
        et[k_ocd] = t; ec[k_ocd] = 0; eb[k_ocd] = 1; ea[k_ocd] = emr_b | 14'h0380; er[k_ocd] = "R6"; t += MRD;
        et[k_ocd+1] = t; ec[k_ocd+1] = 0; eb[k_ocd+1] = 1; ea[k_ocd+1] = emr_b; er[k_ocd+1] = "R6"; t += MRD;
        exp_done = t;

        hold_reset();
        rst_n = 1'b1;
        for (int e = 1; e <= RUN_EDGES; e++) begin
            logic [2:0] code;
            logic act;
            @(negedge clk);
            code = {ddr_ras_n, ddr_cas_n, ddr_we_n};
            act  = !ddr_cs_n && code != 3'b111;
            if (ddr_odt) bad_odt++;
            if (ddr_cke && cke_rise < 0) cke_rise = e;
            if (!ddr_cke && cke_rise >= 0) bad_cke++;
            if (!ddr_cke && !ddr_cs_n) bad_cke++;
            if (init_done && done_rise < 0) done_rise = e;
            if (!init_done && done_rise >= 0) bad_done++;
            if (act && prev_act) bad_len++;
            if (!ddr_cs_n && (code == 3'b101 || code == 3'b100 || code == 3'b011)) bad_col++;
            if (act && done_rise >= 0) bad_quiet++;
            if (act && n < NCMD) begin
                rt[n] = e; rc[n] = int'(code); rb[n] = int'(ddr_ba); ra[n] = int'(ddr_addr);
            end
            if (act) n++;
            prev_act = act;
        end

        chk("R2", "cke rise edge", cke_rise, TS);
        chk("R2", "cke fall or select while low", bad_cke, 0);
        chk("R5", "command count", n, NCMD);
        for (int k = 0; k < NCMD && k < n; k++) begin
            string treq;
            treq = (k == 0) ? "R3" : ((k == k_ocd) ? "R6" : "R7");
            chk(er[k], $sformatf("cmd%0d code", k), rc[k], ec[k]);
            chk(er[k], $sformatf("cmd%0d bank", k), rb[k], eb[k]);
            chk(er[k], $sformatf("cmd%0d addr", k), ra[k], ea[k]);
            chk(treq, $sformatf("cmd%0d edge", k), rt[k], et[k]);
        end
        if (n >= NCMD)
            chk("R6", "gap from DLL reset", int'(rt[k_ocd] - rt[4] >= GAP), 1);
        chk("R8", "multi-cycle command", bad_len, 0);
        chk("R8", "column or activate", bad_col, 0);
        chk("R8", "odt raised", bad_odt, 0);
        chk("R9", "done rise edge", done_rise, exp_done);
        chk("R9", "done dropped", bad_done, 0);
        chk("R9", "command after done", bad_quiet, 0);
    endtask

    // Reset asserted after a given number of edges into a sequence.
    task automatic reset_at(input int at);
        hold_reset();
        rst_n = 1'b1;
        repeat (at) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10", $sformatf("cke after reset at %0d", at), int'(ddr_cke), 0);
        chk("R10", $sformatf("cs_n after reset at %0d", at), int'(ddr_cs_n), 1);
        chk("R10", $sformatf("done after reset at %0d", at), int'(init_done), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        run_seq(14'h0000, 14'h0000);
        run_seq(14'h3fff, 14'h3fff);
        run_seq(14'h0a53, 14'h1c46);
        reset_at(45);
        run_seq(14'h1234, 14'h0385);
        reset_at(80);
        run_seq(14'h2d6b, 14'h2f01);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule